// File: doc/BRIEF.md
# Buffered-Duty PWM Channel

This block is one 8-bit pulse-width modulation channel. A small register port sets the period, the duty threshold, the output polarity, the counting style and the enable. A clock-enable strobe from a prescaler outside the block sets the rate at which the channel counts. The block drives a single output pin.

Two counting styles are available. In edge-aligned mode the counter ramps up and wraps. In center-aligned mode it climbs to the period value and then descends. While the channel runs, a new duty value waits in a shadow register until the next period boundary, so a period never contains a mix of the old and new thresholds. Software reading the duty register always gets back what it last wrote.

Top module: `pwm_channel`

## Requirements
- R1: After reset the period and duty registers read 0xFF and the control register reads 0. The output is 1, which is the inactive level for polarity 0. Register select codes: 0 = period, 1 = duty, 2 = control. Control bits: bit0 enable, bit1 polarity, bit2 center-aligned. All other control bits read 0.
- R2: The counter moves only on clock cycles where `tick` is 1, so the output's period in clock cycles scales with the tick spacing.
- R3: In edge-aligned mode with polarity 1, the counter runs 0..period and then wraps. The output is high for the counts 0..duty, which is (duty+1) of every (period+1) ticks, and low for the rest.
- R4: In center-aligned mode the counter climbs from 0 to the period and then descends back to 0, so one cycle lasts 2×period ticks. With polarity 1 the output is high for 2×duty of those ticks. A duty of 0 gives a constantly low output.
- R5: A duty write while the channel runs reaches the compare logic only at the next period boundary: the wrap in edge-aligned mode, or the return to 0 in center-aligned mode.
- R6: Reading the duty register returns the last written value, even while that value is still waiting in the shadow register.
- R7: When duty ≥ period (and duty ≠ 0xFF), the output never changes and stays at the polarity level.
- R8: A duty of 0xFF holds the running output at the level opposite the polarity bit, whatever the period is.
- R9: While disabled, the output is the inverse of the polarity bit and a duty write takes effect at once. Once enabled, the counter starts at 0 and the first counted slot shows the active level.
- R10: Polarity 0 inverts the waveform. In edge-aligned mode the output is high for (period−duty) of (period+1) ticks. In center-aligned mode it is high for 2×(period−duty) of 2×period ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 1 | Count enable from the external prescaler |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench targets the threshold edges. With duty equal to the period, a design that toggled on the match would lose the full-on level. With duty 0xFF and period 0xFF, a design that only tested duty ≥ period would drive the active level instead of the inactive one. Center-aligned duty 0 catches off-by-one slot counting, which would show as a one-tick pulse. A duty write is placed just after a wrap and the bench checks that the old threshold still governs that period: an unbuffered design would stretch the pulse at once. Enabling after a disabled-time write checks the restart from count 0 with the new duty, where a design that skipped the first slot would shorten the first pulse.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

  // register select codes
  localparam logic [1:0] SEL_PERIOD = 2'd0;
  localparam logic [1:0] SEL_DUTY   = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;

  // control bit positions
  localparam int CTRL_W   = 3;
  localparam int BIT_EN   = 0;
  localparam int BIT_POL  = 1;
  localparam int BIT_CTR  = 2;

  // widest counter the helper functions accept
  localparam int MAX_W = 16;

  // Is the counter slot (value, direction) inside the active part of the cycle?
  function automatic logic active_slot(input logic [MAX_W-1:0] cnt,
                                       input logic [MAX_W-1:0] thr,
                                       input logic             down,
                                       input logic             centered);
    if (centered && !down) return cnt < thr;
    return cnt <= thr;
  endfunction

  // Pin level from the slot test, the all-ones override and the polarity.
  function automatic logic pin_level(input logic active,
                                     input logic force_off,
                                     input logic pol);
    if (force_off) return ~pol;
    return active ? pol : ~pol;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_ch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] period,
  output logic [W-1:0] duty_buf,
  output logic         en,
  output logic         pol,
  output logic         centered
);
  localparam int PAD = W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period   <= '1;
      duty_buf <= '1;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PERIOD: period   <= wr_data;
        SEL_DUTY:   duty_buf <= wr_data;
        SEL_CTRL:   ctrl_q   <= wr_data[CTRL_W-1:0];
        default:    ;
      endcase
    end
  end

  assign en       = ctrl_q[BIT_EN];
  assign pol      = ctrl_q[BIT_POL];
  assign centered = ctrl_q[BIT_CTR];

  always_comb begin
    case (rd_sel)
      SEL_PERIOD: rd_data = period;
      SEL_DUTY:   rd_data = duty_buf;
      SEL_CTRL:   rd_data = {{PAD{1'b0}}, ctrl_q};
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         centered,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         run,
  output logic [W-1:0] cnt_nxt,
  output logic         down_nxt,
  output logic         roll
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic         down;

  always_comb begin
    cnt_nxt  = cnt;
    down_nxt = down;
    roll     = 1'b0;
    if (!run) begin
      cnt_nxt  = '0;
      down_nxt = 1'b0;
    end else if (tick) begin
      if (!centered) begin
        down_nxt = 1'b0;
        if (cnt >= period) begin
          cnt_nxt = '0;
          roll    = 1'b1;
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end else if (period == '0) begin
        cnt_nxt  = '0;
        down_nxt = 1'b0;
        roll     = 1'b1;
      end else if (!down) begin
        if (cnt >= period - ONE) begin
          cnt_nxt  = period;
          down_nxt = 1'b1;
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end else begin
        if (cnt <= ONE) begin
          cnt_nxt  = '0;
          down_nxt = 1'b0;
          roll     = 1'b1;
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
    end
  end

  // run lags enable by one cycle so the count-0 slot is shown after enabling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      run  <= en;
      cnt  <= cnt_nxt;
      down <= down_nxt;
    end
  end

  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(cnt) && $stable(down)));

  p_idle_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !run) |=> (cnt == '0 && !down));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_ch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         run,
  input  logic         pol,
  input  logic         centered,
  input  logic [W-1:0] duty_buf,
  input  logic         roll,
  input  logic [W-1:0] cnt_nxt,
  input  logic         down_nxt,
  output logic         pin
);
  logic [W-1:0] duty_act;
  logic [W-1:0] act_nxt;
  logic         force_off;
  logic         active;
  logic         pin_nxt;

  // shadow transfer: continuous while stopped, at the boundary while running
  always_comb begin
    act_nxt   = (!run || roll) ? duty_buf : duty_act;
    force_off = (act_nxt == '1);
    active    = active_slot(MAX_W'(cnt_nxt), MAX_W'(act_nxt), down_nxt, centered);
    pin_nxt   = en ? pin_level(active, force_off, pol) : ~pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '1;
      pin      <= 1'b1;
    end else begin
      duty_act <= act_nxt;
      pin      <= pin_nxt;
    end
  end

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !roll) |=> $stable(duty_act));

  p_inactive_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pin == !$past(pol)));

  p_ff_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !roll && duty_act == '1) |=> (pin == !$past(pol)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         tick,
  output logic         pwm_out
);
  logic [W-1:0] period;
  logic [W-1:0] duty_buf;
  logic         en;
  logic         pol;
  logic         centered;
  logic         run;
  logic [W-1:0] cnt_nxt;
  logic         down_nxt;
  logic         roll;

  pwm_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .period   (period),
    .duty_buf (duty_buf),
    .en       (en),
    .pol      (pol),
    .centered (centered)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .centered (centered),
    .tick     (tick),
    .period   (period),
    .run      (run),
    .cnt_nxt  (cnt_nxt),
    .down_nxt (down_nxt),
    .roll     (roll)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .run      (run),
    .pol      (pol),
    .centered (centered),
    .duty_buf (duty_buf),
    .roll     (roll),
    .cnt_nxt  (cnt_nxt),
    .down_nxt (down_nxt),
    .pin      (pwm_out)
  );

endmodule

// File: tb/pwm_channel_tb.sv
`timescale 1ns/1ps
module pwm_channel_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [1:0]   rd_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         tick = 1'b0;
  wire  [W-1:0] rd_data;
  wire          pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tick_ph = 0;
  bit done = 1'b0;

  pwm_channel #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .tick(tick), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) tick <= 1'b1;
    else begin
      tick_ph = (tick_ph + 1) % tick_div;
      tick <= (tick_ph == 0);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_sel = sel; wr_data = W'(data); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel = sel; #1; v = int'(rd_data);
  endtask

  task automatic setup(input int per, input int duty, input int ctrl);
    @(negedge clk);
    wr(2, 0); wr(0, per); wr(1, duty); wr(2, ctrl);
    repeat (40) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); if (pwm_out) h++; end
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk("R1", "period reset", v, 255);
    rd(1, v); chk("R1", "duty reset", v, 255);
    rd(2, v); chk("R1", "ctrl reset", v, 0);
    chk("R1", "out reset", int'(pwm_out), 1);
  endtask

  task automatic t_left();
    int h;
    setup(9, 3, 3); count_high(40, h); chk("R3", "edge pol1 high", h, 16);
    setup(9, 3, 1); count_high(40, h); chk("R10", "edge pol0 high", h, 24);
  endtask

  task automatic t_tick();
    int h;
    tick_div = 2;
    setup(9, 3, 3); count_high(80, h); chk("R2", "tick/2 high", h, 32);
    tick_div = 1;
  endtask

  task automatic t_full();
    int h;
    setup(9, 9, 3);  count_high(40, h); chk("R7", "duty=per pol1", h, 40);
    setup(9, 12, 3); count_high(40, h); chk("R7", "duty>per pol1", h, 40);
    setup(9, 9, 1);  count_high(40, h); chk("R7", "duty=per pol0", h, 0);
  endtask

  task automatic t_ff();
    int h;
    setup(9, 255, 3);   count_high(40, h); chk("R8", "ff pol1", h, 0);
    setup(9, 255, 1);   count_high(40, h); chk("R8", "ff pol0", h, 40);
    setup(255, 255, 3); count_high(40, h); chk("R8", "ff per ff", h, 0);
  endtask

  task automatic t_center();
    int h;
    setup(8, 3, 7); count_high(48, h); chk("R4", "center pol1", h, 18);
    setup(8, 0, 7); count_high(48, h); chk("R4", "center duty0", h, 0);
    setup(8, 3, 5); count_high(48, h); chk("R10", "center pol0", h, 30);
  endtask

  task automatic t_shadow();
    int h, v, guard;
    logic prev;
    setup(9, 3, 3);
    prev = pwm_out; guard = 0;
    do begin prev = pwm_out; @(negedge clk); guard++; end
    while (!(pwm_out && !prev) && guard < 50);
    // now at count 0
    wr(1, 7);                      // count 1
    rd(1, v); chk("R6", "pending duty readback", v, 7);
    repeat (2) @(negedge clk);     // count 3
    chk("R5", "old duty slot 3", int'(pwm_out), 1);
    @(negedge clk);                // count 4
    chk("R5", "old duty slot 4", int'(pwm_out), 0);
    repeat (6) @(negedge clk);     // count 0 of next period
    chk("R5", "new period start", int'(pwm_out), 1);
    count_high(9, h);              // counts 1..9
    chk("R5", "new duty applied", h, 7);
  endtask

  task automatic t_disable();
    int h;
    setup(9, 3, 3);
    wr(2, 2);                      // polarity 1, disabled
    @(negedge clk);
    chk("R9", "off level", int'(pwm_out), 0);
    count_high(20, h); chk("R9", "off stays low", h, 0);
    wr(1, 5);
    wr(2, 3);
    @(negedge clk);
    chk("R9", "first slot active", int'(pwm_out), 1);
    count_high(9, h); chk("R9", "restart with new duty", h, 5);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_tick();
    t_full();
    t_ff();
    t_center();
    t_shadow();
    t_disable();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule